// File: doc/BRIEF.md
# Misaligned Load/Store Access Splitter

This block sits between the issue port of a load/store unit and a 64-bit data memory port. It accepts one request at a time. A request carries a byte address, an operand size of 1, 2, 4 or 8 bytes, a direction flag, a byte-reverse flag and store data. A request whose bytes all fall inside one aligned 8-byte double-word goes out as a single memory beat. The alignment of the address within that double-word does not matter. A request whose bytes cross a double-word boundary is split into two beats: the lower double-word first, then the next one.

For loads, the bytes of a split access are gathered in a staging register and merged with the second beat. The result is returned right-justified and zero-extended, with a one-cycle completion pulse. For stores, the operand is rotated onto its byte lanes, and each beat enables only the lanes it owns. A fault reported with either beat's response abandons the whole access and raises a one-cycle restart pulse. The issuer then replays the request from its first beat, even if that beat already completed.

The block is deliberately non-pipelined. From acceptance until completion or restart, it holds its request-ready output low, so only one access, split or not, is ever outstanding.

Top module: `misalign_splitter`

## Requirements
- R1: After synchronous reset, reqReady is 1 and memValid, doneValid and restart are 0.
- R2: When offset + size <= 8 (offset = address bits [2:0]), exactly one beat is issued. Its address has bits [2:0] cleared, and its 8-bit byte enable has bit i set exactly for the lanes offset..offset+size-1.
- R3: When offset + size > 8, two beats are issued. The first goes to the aligned base address with enables for lanes offset..7. The second goes to base + 8 with enables for lanes 0..offset+size-9.
- R4: reqReady is 0 from the cycle after acceptance until the cycle in which doneValid or restart is high; in that cycle it is 1 again.
- R5: A load without byte reverse returns, with doneValid high for exactly one cycle, the memory byte at address + k in doneRdata bits [8k+7:8k] for k < size. All higher bits are 0.
- R6: A store without byte reverse drives operand byte k (reqWdata bits [8k+7:8k]) onto the lane of address + k in the beat that covers that address, with memWrite high.
- R7: A byte-reversed load places the memory byte at address + size - 1 - k into result byte k, with higher bits 0.
- R8: A byte-reversed store writes operand byte size - 1 - k to address + k.
- R9: A fault on the first beat ends the access with a one-cycle restart pulse. No second beat is issued and doneValid does not rise.
- R10: A fault on the second beat of a split access ends it with restart and without doneValid. Replaying the request issues both beats again.
- R11: memValid, memAddr and memBe stay stable until memReady is seen. memValid is 0 while a beat's response is awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle and able to accept |
| reqAddr | input | ADDR_W | Byte address of the operand |
| reqSize | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| reqStore | input | 1 | 1 = store, 0 = load |
| reqSwap | input | 1 | Byte-reverse the operand within its size |
| reqWdata | input | 64 | Store operand, right-justified |
| memValid | output | 1 | Beat request valid |
| memReady | input | 1 | Memory accepts the beat |
| memAddr | output | ADDR_W | Double-word-aligned beat address |
| memWrite | output | 1 | Beat is a write |
| memBe | output | 8 | Byte-lane enables of the beat |
| memWdata | output | 64 | Lane-aligned write data |
| memRespValid | input | 1 | Response for the outstanding beat |
| memFault | input | 1 | Beat faulted (valid with memRespValid) |
| memRdata | input | 64 | Read data of the beat |
| doneValid | output | 1 | One-cycle completion pulse |
| doneRdata | output | 64 | Right-justified load result (0 for stores) |
| restart | output | 1 | One-cycle abort pulse; request must be replayed |

## Verification
A request accepted at one rising edge puts its first beat on memValid in the very next cycle. A beat's response, sampled at an edge, produces doneValid or restart one cycle later, in the same cycle that reqReady returns. A split access therefore needs one more handshake and one more response before its pulse. The bench drives every input at the falling edge and samples every output there, so each result is read in the first full cycle after the edge that registers it. The memory responder stalls every other beat for one cycle to check that the beat is held. Completion is polled cycle by cycle, and the pulse width is confirmed on the following falling edge.

// File: rtl/mas_pkg.sv
package mas_pkg;

  localparam int DATA_W = 64;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE_LO,
    ST_WAIT_LO,
    ST_ISSUE_HI,
    ST_WAIT_HI
  } masState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;     // latch a new request
    logic stageLow;    // keep the lower beat's read data
    logic secondBeat;  // beat fields select the upper double-word
    logic finish;      // register the merged load result
  } masStrobe_t;

  function automatic logic [LANES-1:0] sizeMask(logic [1:0] sz);
    logic [LANES-1:0] m;
    case (sz)
      2'd0:    m = 8'h01;
      2'd1:    m = 8'h03;
      2'd2:    m = 8'h0F;
      default: m = 8'hFF;
    endcase
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] expandMask(logic [LANES-1:0] m);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < LANES; i++) r[8*i +: 8] = {8{m[i]}};
    return r;
  endfunction

  // reverse the lowest (1<<sz) bytes, clear the rest
  function automatic logic [DATA_W-1:0] swapBytes(logic [DATA_W-1:0] d, logic [1:0] sz);
    logic [DATA_W-1:0] r;
    int n;
    r = '0;
    n = 1 << sz;
    for (int i = 0; i < LANES; i++) begin
      if (i < n) r[8*i +: 8] = d[8*(n-1-i) +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/mas_ctrl.sv
module mas_ctrl
  import mas_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  output logic       reqReady,
  output logic       memValid,
  input  logic       memReady,
  input  logic       memRespValid,
  input  logic       memFault,
  input  logic       isSplit,
  output logic       doneValid,
  output logic       restart,
  output masStrobe_t strobe
);

  masState_t state, stateNext;
  logic doneNext, restartNext;

  always_comb begin
    stateNext   = state;
    strobe      = '0;
    doneNext    = 1'b0;
    restartNext = 1'b0;
    reqReady    = 1'b0;
    memValid    = 1'b0;
    case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.capture = 1'b1;
          stateNext      = ST_ISSUE_LO;
        end
      end
      ST_ISSUE_LO: begin
        memValid = 1'b1;
        if (memReady) stateNext = ST_WAIT_LO;
      end
      ST_WAIT_LO: begin
        if (memRespValid) begin
          if (memFault) begin
            restartNext = 1'b1;
            stateNext   = ST_IDLE;
          end else if (isSplit) begin
            strobe.stageLow = 1'b1;
            stateNext       = ST_ISSUE_HI;
          end else begin
            strobe.finish = 1'b1;
            doneNext      = 1'b1;
            stateNext     = ST_IDLE;
          end
        end
      end
      ST_ISSUE_HI: begin
        memValid          = 1'b1;
        strobe.secondBeat = 1'b1;
        if (memReady) stateNext = ST_WAIT_HI;
      end
      ST_WAIT_HI: begin
        strobe.secondBeat = 1'b1;
        if (memRespValid) begin
          if (memFault) begin
            restartNext = 1'b1;
          end else begin
            strobe.finish = 1'b1;
            doneNext      = 1'b1;
          end
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      doneValid <= 1'b0;
      restart   <= 1'b0;
    end else begin
      state     <= stateNext;
      doneValid <= doneNext;
      restart   <= restartNext;
    end
  end

  // R4
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (rst)
    memValid |-> !reqReady);

  // R11
  beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (memValid && !memReady) |=> memValid);

  // R9
  done_restart_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(doneValid && restart));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    doneValid |=> !doneValid);

  // R11
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    (memValid && memReady) |=> !memValid);

endmodule

// File: rtl/mas_dpath.sv
module mas_dpath
  import mas_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [1:0]          reqSize,
  input  logic                reqStore,
  input  logic                reqSwap,
  input  logic [DATA_W-1:0]   reqWdata,
  input  masStrobe_t          strobe,
  input  logic [DATA_W-1:0]   memRdata,
  output logic                isSplit,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memWrite,
  output logic [LANES-1:0]    memBe,
  output logic [DATA_W-1:0]   memWdata,
  output logic [DATA_W-1:0]   doneRdata
);

  localparam int OFF_W  = $clog2(LANES);
  localparam int WIDE_W = 2 * DATA_W;

  logic [ADDR_W-1:0]  addrQ;
  logic [1:0]         sizeQ;
  logic               storeQ, swapQ;
  logic [WIDE_W-1:0]  laneQ;
  logic [2*LANES-1:0] maskQ;
  logic [DATA_W-1:0]  stageQ, rdataQ;

  // request-side lane placement
  logic [OFF_W-1:0]   reqOff;
  logic [2*LANES-1:0] reqMask;
  logic [DATA_W-1:0]  reqOperand;
  logic [WIDE_W-1:0]  reqLanes;

  always_comb begin
    reqOff     = reqAddr[OFF_W-1:0];
    reqMask    = {{LANES{1'b0}}, sizeMask(reqSize)} << reqOff;
    reqOperand = reqSwap ? swapBytes(reqWdata, reqSize)
                         : (reqWdata & expandMask(sizeMask(reqSize)));
    reqLanes   = {{DATA_W{1'b0}}, reqOperand} << {reqOff, 3'b000};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ  <= '0;
      sizeQ  <= '0;
      storeQ <= 1'b0;
      swapQ  <= 1'b0;
      laneQ  <= '0;
      maskQ  <= '0;
      stageQ <= '0;
      rdataQ <= '0;
    end else begin
      if (strobe.capture) begin
        addrQ  <= reqAddr;
        sizeQ  <= reqSize;
        storeQ <= reqStore;
        swapQ  <= reqSwap;
        laneQ  <= reqLanes;
        maskQ  <= reqMask;
      end
      if (strobe.stageLow) stageQ <= memRdata;
      if (strobe.finish)   rdataQ <= storeQ ? '0 : loadResult;
    end
  end

  // beat fields
  logic [ADDR_W-1:0] baseAddr;
  assign baseAddr = {addrQ[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign memAddr  = baseAddr + {{(ADDR_W-OFF_W-1){1'b0}}, strobe.secondBeat, {OFF_W{1'b0}}};
  assign isSplit  = |maskQ[2*LANES-1:LANES];
  assign memWrite = storeQ;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign memBe[g]            = strobe.secondBeat ? maskQ[LANES+g] : maskQ[g];
      assign memWdata[8*g +: 8]  = strobe.secondBeat ? laneQ[DATA_W+8*g +: 8] : laneQ[8*g +: 8];
    end
  endgenerate

  // load merge
  logic [WIDE_W-1:0] combined;
  logic [DATA_W-1:0] shifted, trimmed, loadResult;

  always_comb begin
    combined   = isSplit ? {memRdata, stageQ} : {{DATA_W{1'b0}}, memRdata};
    shifted    = DATA_W'(combined >> {addrQ[OFF_W-1:0], 3'b000});
    trimmed    = shifted & expandMask(sizeMask(sizeQ));
    loadResult = swapQ ? swapBytes(trimmed, sizeQ) : trimmed;
  end

  assign doneRdata = rdataQ;

  // R2
  beat_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.secondBeat || strobe.stageLow) |-> (memBe != '0));

  // R3
  second_addr_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe.secondBeat) |-> (memAddr == $past(memAddr) + ADDR_W'(LANES)));

endmodule

// File: rtl/misalign_splitter.sv
module misalign_splitter
  import mas_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqStore,
  input  logic              reqSwap,
  input  logic [63:0]       reqWdata,
  output logic              memValid,
  input  logic              memReady,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrite,
  output logic [7:0]        memBe,
  output logic [63:0]       memWdata,
  input  logic              memRespValid,
  input  logic              memFault,
  input  logic [63:0]       memRdata,
  output logic              doneValid,
  output logic [63:0]       doneRdata,
  output logic              restart
);

  masStrobe_t strobe;
  logic       isSplit;

  mas_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .reqValid     (reqValid),
    .reqReady     (reqReady),
    .memValid     (memValid),
    .memReady     (memReady),
    .memRespValid (memRespValid),
    .memFault     (memFault),
    .isSplit      (isSplit),
    .doneValid    (doneValid),
    .restart      (restart),
    .strobe       (strobe)
  );

  mas_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .reqAddr   (reqAddr),
    .reqSize   (reqSize),
    .reqStore  (reqStore),
    .reqSwap   (reqSwap),
    .reqWdata  (reqWdata),
    .strobe    (strobe),
    .memRdata  (memRdata),
    .isSplit   (isSplit),
    .memAddr   (memAddr),
    .memWrite  (memWrite),
    .memBe     (memBe),
    .memWdata  (memWdata),
    .doneRdata (doneRdata)
  );

  // R11
  beat_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (memValid && !memReady) |=> ($stable(memAddr) && $stable(memBe) && $stable(memWdata)));

endmodule

// File: tb/misalign_splitter_test.sv
module misalign_splitter_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst;
  logic reqValid, reqReady, reqStore, reqSwap;
  logic [AW-1:0] reqAddr;
  logic [1:0] reqSize;
  logic [63:0] reqWdata;
  logic memValid, memReady, memWrite, memRespValid, memFault;
  logic [AW-1:0] memAddr;
  logic [7:0] memBe;
  logic [63:0] memWdata, memRdata, doneRdata;
  logic doneValid, restart;

  always #(CLK_PERIOD/2) clk = ~clk;

  misalign_splitter #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqStore(reqStore), .reqSwap(reqSwap),
    .reqWdata(reqWdata), .memValid(memValid), .memReady(memReady),
    .memAddr(memAddr), .memWrite(memWrite), .memBe(memBe), .memWdata(memWdata),
    .memRespValid(memRespValid), .memFault(memFault), .memRdata(memRdata),
    .doneValid(doneValid), .doneRdata(doneRdata), .restart(restart)
  );

  int total = 0;
  int bad = 0;
  logic [7:0] mem [0:31];
  int beatCount;
  logic [AW-1:0] beatAddr [0:1];
  logic [7:0] beatBe [0:1];
  int faultAt;
  bit stallToggle = 1'b0;
  logic [63:0] rngState = 64'h9E3779B97F4A7C15;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] nextRand(logic [63:0] s);
    logic [63:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  // memory responder: stalls every other beat one cycle
  initial begin
    memReady = 1'b0; memRespValid = 1'b0; memFault = 1'b0; memRdata = '0;
    forever begin
      @(negedge clk);
      if (memValid) begin
        logic [AW-1:0] a;
        logic [7:0] be;
        logic [63:0] wd;
        logic wr;
        if (stallToggle) begin
          stallToggle = 1'b0;
          a = memAddr; be = memBe;
          @(negedge clk);
          check(memValid && memAddr == a && memBe == be, "R11", "beat held under stall",
                {memValid, memAddr, memBe}, {1'b1, a, be});
        end else begin
          stallToggle = 1'b1;
        end
        memReady = 1'b1;
        a = memAddr; be = memBe; wd = memWdata; wr = memWrite;
        if (beatCount < 2) begin
          beatAddr[beatCount] = a;
          beatBe[beatCount] = be;
        end
        beatCount++;
        @(negedge clk);
        memReady = 1'b0;
        check(!memValid, "R11", "no beat while awaiting response", 64'(memValid), 64'd0);
        memRespValid = 1'b1;
        memFault = (faultAt == beatCount);
        for (int b = 0; b < 8; b++) memRdata[8*b +: 8] = mem[int'(a[4:3]) * 8 + b];
        if (wr && !memFault) begin
          for (int b = 0; b < 8; b++)
            if (be[b]) mem[int'(a[4:3]) * 8 + b] = wd[8*b +: 8];
        end
        @(negedge clk);
        memRespValid = 1'b0;
        memFault = 1'b0;
      end
    end
  end

  // issue one request, wait for done or restart
  task automatic runReq(input logic [AW-1:0] a, input logic [1:0] sz, input bit st,
                        input bit sw, input logic [63:0] wd, input int fa,
                        output bit gotDone, output bit gotRestart, output logic [63:0] rd);
    bit busyBad;
    bit seen;
    beatCount = 0;
    faultAt = fa;
    gotDone = 1'b0; gotRestart = 1'b0; rd = '0; busyBad = 1'b0; seen = 1'b0;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqSize = sz; reqStore = st; reqSwap = sw; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (doneValid || restart) begin
        gotDone = doneValid; gotRestart = restart; rd = doneRdata; seen = 1'b1;
        break;
      end
      if (reqReady) busyBad = 1'b1;
      @(negedge clk);
    end
    check(seen && !busyBad && reqReady, "R4", "ready low while busy, high at end",
          {busyBad, reqReady}, 64'd1);
    @(negedge clk);
    check(!doneValid && !restart, "R5", "completion is a single-cycle pulse",
          {doneValid, restart}, 64'd0);
  endtask

  task automatic checkBeats(input logic [AW-1:0] a, input logic [1:0] sz, input int fa);
    int n, nb, expCnt;
    logic [7:0] be0, be1;
    logic [AW-1:0] a0;
    n = 1 << sz;
    be0 = '0; be1 = '0;
    for (int k = 0; k < n; k++) begin
      int byteA;
      byteA = int'(a) + k;
      if ((byteA >> 3) == (int'(a) >> 3)) be0[byteA & 7] = 1'b1;
      else be1[byteA & 7] = 1'b1;
    end
    a0 = a & ~AW'(7);
    nb = (be1 != 0) ? 2 : 1;
    expCnt = (fa == 1) ? 1 : nb;
    if (nb == 1) begin
      check(beatCount == expCnt && beatAddr[0] == a0 && beatBe[0] == be0, "R2",
            $sformatf("single beat a=%0d sz=%0d", a, sz),
            {32'(beatCount), 16'(beatAddr[0]), beatBe[0]}, {32'(expCnt), 16'(a0), be0});
    end else if (expCnt == 1) begin
      check(beatCount == 1 && beatAddr[0] == a0 && beatBe[0] == be0, "R9",
            $sformatf("first-beat fault a=%0d", a),
            {32'(beatCount), 16'(beatAddr[0]), beatBe[0]}, {32'd1, 16'(a0), be0});
    end else begin
      check(beatCount == 2 && beatAddr[0] == a0 && beatBe[0] == be0 &&
            beatAddr[1] == a0 + AW'(8) && beatBe[1] == be1, "R3",
            $sformatf("split beats a=%0d sz=%0d", a, sz),
            {16'(beatCount), beatBe[0], beatBe[1], 16'(beatAddr[1])},
            {16'd2, be0, be1, 16'(a0 + AW'(8))});
    end
  endtask

  function automatic logic [63:0] expLoad(logic [AW-1:0] a, logic [1:0] sz, bit sw);
    logic [63:0] r;
    int n;
    r = '0;
    n = 1 << sz;
    for (int k = 0; k < n; k++) r[8*k +: 8] = mem[int'(a) + (sw ? n - 1 - k : k)];
    return r;
  endfunction

  task automatic checkStore(input logic [AW-1:0] a, input logic [1:0] sz, input bit sw,
                            input logic [63:0] wd, input string tag);
    int n;
    logic [63:0] act, exp;
    n = 1 << sz;
    act = '0; exp = '0;
    for (int k = 0; k < n; k++) begin
      act[8*k +: 8] = mem[int'(a) + k];
      exp[8*k +: 8] = wd[8*(sw ? n - 1 - k : k) +: 8];
    end
    check(act == exp, tag, $sformatf("store bytes a=%0d sz=%0d", a, sz), act, exp);
  endtask

  initial begin
    bit dn, rs;
    logic [63:0] rd, ex, wd;
    for (int i = 0; i < 32; i++) mem[i] = 8'(i * 37 + 5);
    faultAt = 0; beatCount = 0;
    reqValid = 1'b0; reqAddr = '0; reqSize = '0; reqStore = 1'b0; reqSwap = 1'b0; reqWdata = '0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(reqReady && !memValid && !doneValid && !restart, "R1", "reset state",
          {reqReady, memValid, doneValid, restart}, 64'b1000);
    rst = 1'b0;

    // sweep: two base double-words, every offset, size, direction, swap
    for (int base = 0; base < 16; base += 8) begin
      for (int off = 0; off < 8; off++) begin
        for (int sz = 0; sz < 4; sz++) begin
          for (int st = 0; st < 2; st++) begin
            for (int sw = 0; sw < 2; sw++) begin
              logic [AW-1:0] a;
              a = AW'(base + off);
              rngState = nextRand(rngState);
              wd = rngState;
              ex = expLoad(a, 2'(sz), sw[0]);
              runReq(a, 2'(sz), st[0], sw[0], wd, 0, dn, rs, rd);
              check(dn && !rs, "R5", "request completes", {dn, rs}, 64'b10);
              checkBeats(a, 2'(sz), 0);
              if (st == 0)
                check(rd == ex, sw ? "R7" : "R5",
                      $sformatf("load a=%0d sz=%0d", a, sz), rd, ex);
              else
                checkStore(a, 2'(sz), sw[0], wd, sw ? "R8" : "R6");
            end
          end
        end
      end
    end

    // fault on first beat of a split load
    runReq(AW'(6), 2'd2, 1'b0, 1'b0, 64'h0, 1, dn, rs, rd);
    check(rs && !dn, "R9", "first-beat fault restarts", {dn, rs}, 64'b01);
    checkBeats(AW'(6), 2'd2, 1);

    // fault on first beat of a contained store: memory untouched
    ex = expLoad(AW'(0), 2'd3, 1'b0);
    runReq(AW'(0), 2'd3, 1'b1, 1'b0, 64'hDEAD_BEEF_0123_4567, 1, dn, rs, rd);
    check(rs && !dn && beatCount == 1, "R9", "contained fault restarts",
          {dn, rs, 8'(beatCount)}, {2'b01, 8'd1});
    rd = expLoad(AW'(0), 2'd3, 1'b0);
    check(rd == ex, "R9", "faulted store wrote nothing", rd, ex);

    // fault on second beat of a split store, then replay
    wd = 64'h1122_3344_5566_7788;
    runReq(AW'(13), 2'd3, 1'b1, 1'b0, wd, 2, dn, rs, rd);
    check(rs && !dn, "R10", "second-beat fault restarts", {dn, rs}, 64'b01);
    check(beatCount == 2, "R10", "both beats issued before fault", 64'(beatCount), 64'd2);
    runReq(AW'(13), 2'd3, 1'b1, 1'b0, wd, 0, dn, rs, rd);
    check(dn && !rs, "R10", "replay completes", {dn, rs}, 64'b10);
    checkBeats(AW'(13), 2'd3, 0);
    check(beatAddr[0] == AW'(8), "R10", "replay repeats first beat", 64'(beatAddr[0]), 64'd8);
    checkStore(AW'(13), 2'd3, 1'b0, wd, "R10");

    // second-beat fault on a swapped load, then replay
    ex = expLoad(AW'(7), 2'd1, 1'b1);
    runReq(AW'(7), 2'd1, 1'b0, 1'b1, 64'h0, 2, dn, rs, rd);
    check(rs && !dn, "R10", "load second-beat fault", {dn, rs}, 64'b01);
    runReq(AW'(7), 2'd1, 1'b0, 1'b1, 64'h0, 0, dn, rs, rd);
    check(dn && rd == ex, "R7", "replayed swapped load", rd, ex);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule